// File: doc/BRIEF.md
# XOR Beat Dither PWM Generator

This block turns one master clock into a pulse stream whose duty cycle climbs and falls linearly, so that after an external low-pass filter the result is a symmetrical triangle. It is intended as a dither source for proportional actuator drives. There is no duty-cycle counter or compare register. Two half-period dividers make two 50% square waves, one with a full period of n+1 master cycles and one with n-1. The PWM output is simply their exclusive-OR. The slow beat between the two clocks is the triangle, at 2·fclk/(n²−1). The carrier the filter must remove sits at the sum of the two clock frequencies.

The ratio n is an odd run-time input of at least 3. A malformed value is refused and the last good one stays in use. A new good value waits for the next point where both clocks return low together, so a triangle period is never cut short. A one-cycle strobe marks that point. With a 10 MHz master clock and n = 317, the triangle comes out near 199 Hz.

Top module: `xor_dither_pwm`

## Requirements
- R1: While rst_ni is low, clk_a_o, clk_b_o, pwm_o, period_stb_o and n_err_o are all 0.
- R2: k counts the enabled clock edges since the last start. After k such edges, clk_a_o equals floor(k / ((n+1)/2)) mod 2. This gives a 50% clock with a period of n+1 master cycles.
- R3: After k enabled edges, clk_b_o equals floor(k / ((n-1)/2)) mod 2. This gives a 50% clock with a period of n-1 master cycles. With n = 3 it toggles on every edge.
- R4: pwm_o is at all times the exclusive-OR of clk_a_o and clk_b_o.
- R5: period_stb_o is high for exactly the one cycle in which k+1 is a multiple of (n²−1)/2 and en_i is high. In that cycle both clocks are high, and both are low after the next edge. The next edge is the start of a new period, with k = 0.
- R6: A value on n_i is invalid when its bit 0 is 0 or it is below 3. The cycle after an invalid value is sampled, n_err_o is 1. Otherwise n_err_o is 0. An invalid value changes neither the pending nor the active ratio.
- R7: A valid n_i becomes the active ratio only at an edge where period_stb_o is high, or at an edge where en_i is low. Until then, both clocks keep following the old ratio.
- R8: At an edge where en_i is low, both dividers clear: the clocks go to 0 and k goes to 0. Counting resumes from k = 0 at the first edge where en_i is high.
- R9: With n = 317, the first strobe after a start appears at k = 50243, one cycle before the 50244th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears both dividers |
| n_i | input | NW | Requested odd division ratio n |
| clk_a_o | output | 1 | Square wave at fclk/(n+1) |
| clk_b_o | output | 1 | Square wave at fclk/(n-1) |
| pwm_o | output | 1 | XOR of the two clocks |
| period_stb_o | output | 1 | One-cycle mark at each triangle restart |
| n_err_o | output | 1 | Previous n_i sample was invalid |

## Verification
The checker assumes that n_i and en_i are driven to known values from the first clock edge, and that the reset value of the active ratio is itself a valid odd number of at least 3. Only then is the strobe tied to both clocks being high. The bench changes inputs one time unit after a rising edge and samples at the falling edge, so every input holds steady across the edge that samples it. The bench applies odd ratios from 3 to 317, plus even values, 1 and 0. Its model then predicts each output cycle from the edge count and the ratio it expects to be active.

// File: rtl/xdp_pkg.sv
package xdp_pkg;
  localparam int unsigned N_W   = 16;
  localparam int unsigned N_RST = 317;
  localparam int unsigned N_DIV = 2;  // index 0: n+1 divider, index 1: n-1 divider
endpackage

// File: rtl/xdp_half_div.sv
module xdp_half_div #(
  parameter int unsigned NW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NW-1:0] reload_i,
  output logic          wrap_o,
  output logic          clk_o
);
  logic [NW-1:0] cnt_q;
  logic          hit;

  assign hit    = (cnt_q == reload_i);
  assign wrap_o = en_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      clk_o <= ~clk_o;
    end else begin
      cnt_q <= cnt_q + NW'(1);
    end
  end
endmodule

// File: rtl/xdp_n_ctrl.sv
module xdp_n_ctrl #(
  parameter int unsigned NW     = 16,
  parameter int unsigned N_INIT = 317
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          align_i,
  input  logic [NW-1:0] n_i,
  output logic [NW-1:0] n_act_o,
  output logic          err_o
);
  logic [NW-1:0] pend_q, nxt;
  logic          n_ok;

  assign n_ok = n_i[0] & (n_i >= NW'(3));
  assign nxt  = n_ok ? n_i : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= NW'(N_INIT);
      n_act_o <= NW'(N_INIT);
      err_o   <= 1'b0;
    end else begin
      pend_q <= nxt;
      err_o  <= ~n_ok;
      // adopt only when stopped or at a common low-low restart
      if (!en_i || align_i) n_act_o <= nxt;
    end
  end
endmodule

// File: rtl/xor_dither_pwm.sv
module xor_dither_pwm #(
  parameter int unsigned NW     = xdp_pkg::N_W,
  parameter int unsigned N_INIT = xdp_pkg::N_RST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NW-1:0] n_i,
  output logic          clk_a_o,
  output logic          clk_b_o,
  output logic          pwm_o,
  output logic          period_stb_o,
  output logic          n_err_o
);
  localparam int unsigned ND = xdp_pkg::N_DIV;

  logic [NW-1:0] n_act;
  logic [NW-1:0] reload [ND];
  logic [ND-1:0] wrap, div_clk;
  logic          align;

  // half-period reload = (n + 1 - 2*i)/2 - 1 = (n - (2*i+1)) / 2
  always_comb begin
    for (int i = 0; i < ND; i++) reload[i] = (n_act - NW'(2*i+1)) >> 1;
  end

  for (genvar g = 0; g < ND; g++) begin : g_div
    xdp_half_div #(.NW(NW)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .reload_i (reload[g]),
      .wrap_o   (wrap[g]),
      .clk_o    (div_clk[g])
    );
  end

  // both wrap while both high: next state is the in-phase start
  assign align = (&wrap) & (&div_clk);

  xdp_n_ctrl #(.NW(NW), .N_INIT(N_INIT)) u_nctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .align_i (align),
    .n_i     (n_i),
    .n_act_o (n_act),
    .err_o   (n_err_o)
  );

  assign clk_a_o      = div_clk[0];
  assign clk_b_o      = div_clk[1];
  assign pwm_o        = div_clk[0] ^ div_clk[1];
  assign period_stb_o = align;
endmodule

// File: rtl/xor_dither_pwm_chk.sv
module xor_dither_pwm_chk #(
  parameter int unsigned NW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [NW-1:0] n_i,
  input logic          clk_a_o,
  input logic          clk_b_o,
  input logic          period_stb_o,
  input logic          n_err_o,
  input logic [NW-1:0] n_act
);
  assert_stb_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_stb_o |-> (clk_a_o && clk_b_o));

  assert_stb_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_stb_o |=> (!clk_a_o && !clk_b_o));

  assert_even_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !n_i[0] |=> n_err_o);

  assert_hold_ratio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !period_stb_o) |=> $stable(n_act));

  assert_disable_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!clk_a_o && !clk_b_o && !period_stb_o));
endmodule

bind xor_dither_pwm xor_dither_pwm_chk #(.NW(NW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .n_i          (n_i),
  .clk_a_o      (clk_a_o),
  .clk_b_o      (clk_b_o),
  .period_stb_o (period_stb_o),
  .n_err_o      (n_err_o),
  .n_act        (n_act)
);

// File: tb/xor_dither_pwm_bench.sv
module xor_dither_pwm_bench;
  localparam int NW   = 16;
  localparam int NRST = 317;
  localparam int NV   = 6;
  // {n, enabled cycles to observe}
  localparam int VEC [NV][2] = '{'{3, 20}, '{5, 30}, '{7, 60}, '{9, 100}, '{11, 150}, '{15, 250}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [NW-1:0] n_in = NW'(NRST);
  logic          clk_a, clk_b, pwm, stb, err;

  int checks = 0, fails = 0;
  bit done = 0;
  int k = 0, n_m = NRST, p_m = NRST;
  bit err_m = 0, last_stb = 0;

  always #2 clk = ~clk;

  xor_dither_pwm #(.NW(NW), .N_INIT(NRST)) u_xor_dither_pwm (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .n_i(n_in),
    .clk_a_o(clk_a), .clk_b_o(clk_b), .pwm_o(pwm),
    .period_stb_o(stb), .n_err_o(err)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(string ctx);
    int ea, eb, es, pp;
    bit ok;
    @(negedge clk);
    pp = (n_m * n_m - 1) / 2;
    ea = (k / ((n_m + 1) / 2)) % 2;
    eb = (k / ((n_m - 1) / 2)) % 2;
    es = (en && ((k + 1) % pp == 0)) ? 1 : 0;
    last_stb = stb;
    chk({ctx, " R2 clk_a"}, int'(clk_a), ea);
    chk({ctx, " R3 clk_b"}, int'(clk_b), eb);
    chk({ctx, " R4 pwm"}, int'(pwm), ea ^ eb);
    chk({ctx, " R5 strobe"}, int'(stb), es);
    chk({ctx, " R6 err"}, int'(err), int'(err_m));
    @(posedge clk);
    #1;
    ok = n_in[0] && (n_in >= 3);
    err_m = !ok;
    if (ok) p_m = int'(n_in);
    if (!en) begin k = 0; n_m = p_m; end
    else if (es == 1) begin k = 0; n_m = p_m; end
    else k++;
  endtask

  task automatic restart(int n, string ctx);
    n_in = NW'(n);
    en = 1'b0;
    tick(ctx);
    tick(ctx);
    en = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int first;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 clk_a", int'(clk_a), 0);
    chk("R1 clk_b", int'(clk_b), 0);
    chk("R1 pwm", int'(pwm), 0);
    chk("R1 strobe", int'(stb), 0);
    chk("R1 err", int'(err), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // table of ratios
    for (int v = 0; v < NV; v++) begin
      restart(VEC[v][0], "vec");
      for (int c = 0; c < VEC[v][1]; c++) tick("vec");
    end

    // R7: change ratio mid-period, takes effect only after strobe
    restart(5, "R7");
    repeat (3) tick("R7");
    n_in = NW'(7);
    repeat (9) tick("R7");
    chk("R7 old ratio kept until strobe", int'(last_stb), 1);
    repeat (60) tick("R7");

    // R6: invalid values ignored, flag raised
    n_in = NW'(4);
    repeat (10) tick("R6 even");
    n_in = NW'(1);
    repeat (10) tick("R6 one");
    n_in = NW'(0);
    repeat (40) tick("R6 zero");
    n_in = NW'(7);
    repeat (30) tick("R6 valid");

    // R8: enable drop mid-run, new ratio while stopped
    repeat (5) tick("R8");
    en = 1'b0;
    tick("R8");
    n_in = NW'(9);
    tick("R8");
    chk("R8 clk_a cleared", int'(clk_a), 0);
    chk("R8 clk_b cleared", int'(clk_b), 0);
    tick("R8");
    en = 1'b1;
    repeat (90) tick("R8");

    // R9: long ratio, first strobe position
    restart(317, "R9");
    first = -1;
    for (int t = 0; t < 50250; t++) begin
      tick("R9");
      if (last_stb && first < 0) first = t;
    end
    chk("R9 first strobe index", first, 50243);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule